// File: doc/BRIEF.md
# DRAM Refresh Address Generator

This block supplies the row address and strobes that a dynamic memory needs for a refresh cycle slipped in after each opcode fetch. It holds two 8-bit registers: a refresh counter, whose low seven bits advance once per completed fetch, and a page register that forms the upper address byte. The counter's top bit is not part of the count. It keeps the value of the most recent explicit load.

An external sequencer pulses `fetch_done_i` when an opcode fetch completes, then raises `win_i` for the refresh window while the fetched instruction is decoded. While the window is open, the block drives `{page, counter}` on `ref_addr_o` and pulls both active-low strobes. The refresh happens inside the window that the sequencer already provides, so it costs the processor no cycles. Both registers can be loaded from an 8-bit data input, for example from an accumulator for test use, and their values are read back at all times.

Top module: `ra_refresh_gen`

## Requirements
- R1: On a rising clock edge where `fetch_done_i` is 1 and `ld_cnt_i` is 0, counter bits [6:0] increase by one.
- R2: Counter bit 7 changes only on an explicit counter load. Increments leave it unchanged.
- R3: Counter bits [6:0] wrap from 7Fh to 00h on an increment, and bit 7 keeps its value (7Fh becomes 00h, FFh becomes 80h).
- R4: On a rising edge with `ld_cnt_i` = 1, the whole counter takes `ld_data_i`. A load has priority over a same-cycle increment.
- R5: On a rising edge with `ld_page_i` = 1, the page register takes `ld_data_i`. Otherwise it holds its value, including across fetches.
- R6: While `win_i` = 1, `ref_addr_o[15:8]` equals the page register and `ref_addr_o[7:0]` equals the counter, and `ref_strb_no` and `mem_strb_no` are both 0. These outputs follow `win_i` in the same cycle, with no register delay.
- R7: While `win_i` = 0, `ref_strb_no` and `mem_strb_no` are both 1 and `ref_addr_o` is 0000h.
- R8: While `rst_ni` = 0, both registers are cleared to 00h.
- R9: `cnt_o` and `page_o` always show the current counter and page register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_done_i | input | 1 | One-cycle pulse when an opcode fetch completes |
| win_i | input | 1 | Refresh window from the external sequencer |
| ld_cnt_i | input | 1 | Load strobe for the refresh counter |
| ld_page_i | input | 1 | Load strobe for the page register |
| ld_data_i | input | 8 | Data for either load |
| ref_addr_o | output | 16 | Refresh address, {page, counter} in the window, else zero |
| ref_strb_no | output | 1 | Refresh strobe, active low |
| mem_strb_no | output | 1 | Memory request strobe, active low |
| cnt_o | output | 8 | Counter readback |
| page_o | output | 8 | Page register readback |

## Verification
The assertions check several behaviours on every cycle. They check the seven-bit increment step, that bit 7 stays put without a load, and that a load lands exactly. They check that the page register holds and that the two strobes move together. They also check that the address is the register pair inside the window and zero outside it. Only the bench scenarios show three further behaviours: the exact wrap values 7Fh to 00h and FFh to 80h, a load winning over a same-cycle fetch, and the reset contents. They also show that the window outputs respond within the same cycle as `win_i`.

// File: rtl/ra_pkg.sv
`timescale 1ns/1ps
package ra_pkg;
  localparam int unsigned RA_CNT_W  = 8;
  localparam int unsigned RA_PAGE_W = 8;

  typedef enum logic [1:0] {
    SEL_HOLD = 2'd0,
    SEL_INC  = 2'd1,
    SEL_LOAD = 2'd2
  } cnt_sel_e;
endpackage

// File: rtl/ra_cnt_reg.sv
`timescale 1ns/1ps
module ra_cnt_reg
  import ra_pkg::*;
#(
  parameter int unsigned CNT_W = RA_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_data_i,
  output logic [CNT_W-1:0] q_o
);
  localparam int unsigned CYC_W = CNT_W - 1;

  cnt_sel_e         sel;
  logic [CNT_W-1:0] q_d, q_q;
  logic [CYC_W-1:0] cyc_nxt;

  // load has priority over increment
  always_comb begin
    if (ld_i)       sel = SEL_LOAD;
    else if (inc_i) sel = SEL_INC;
    else            sel = SEL_HOLD;
  end

  assign cyc_nxt = q_q[CYC_W-1:0] + {{(CYC_W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (sel)
      SEL_LOAD: q_d = ld_data_i;
      SEL_INC:  q_d = {q_q[CNT_W-1], cyc_nxt};
      default:  q_d = q_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/ra_page_reg.sv
`timescale 1ns/1ps
module ra_page_reg
  import ra_pkg::*;
#(
  parameter int unsigned PAGE_W = RA_PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [PAGE_W-1:0] ld_data_i,
  output logic [PAGE_W-1:0] q_o
);
  logic [PAGE_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (ld_i) q_q <= ld_data_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/ra_addr_drv.sv
`timescale 1ns/1ps
module ra_addr_drv
  import ra_pkg::*;
#(
  parameter int unsigned CNT_W  = RA_CNT_W,
  parameter int unsigned PAGE_W = RA_PAGE_W
) (
  input  logic                    win_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [PAGE_W-1:0]       page_i,
  output logic [PAGE_W+CNT_W-1:0] addr_o,
  output logic                    ref_strb_no,
  output logic                    mem_strb_no
);
  localparam int unsigned ADDR_W = PAGE_W + CNT_W;

  logic [ADDR_W-1:0] src;
  assign src = {page_i, cnt_i};

  // gate each address line with the window; bus idles at zero
  for (genvar i = 0; i < ADDR_W; i++) begin : g_gate
    assign addr_o[i] = win_i & src[i];
  end

  assign ref_strb_no = ~win_i;
  assign mem_strb_no = ~win_i;
endmodule

// File: rtl/ra_refresh_gen.sv
`timescale 1ns/1ps
module ra_refresh_gen
  import ra_pkg::*;
#(
  parameter int unsigned CNT_W  = RA_CNT_W,
  parameter int unsigned PAGE_W = RA_PAGE_W,
  localparam int unsigned DAT_W  = (CNT_W > PAGE_W) ? CNT_W : PAGE_W,
  localparam int unsigned ADDR_W = PAGE_W + CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_done_i,
  input  logic              win_i,
  input  logic              ld_cnt_i,
  input  logic              ld_page_i,
  input  logic [DAT_W-1:0]  ld_data_i,
  output logic [ADDR_W-1:0] ref_addr_o,
  output logic              ref_strb_no,
  output logic              mem_strb_no,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [PAGE_W-1:0] page_o
);
  logic [CNT_W-1:0]  cnt;
  logic [PAGE_W-1:0] page;

  ra_cnt_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (fetch_done_i),
    .ld_i      (ld_cnt_i),
    .ld_data_i (ld_data_i[CNT_W-1:0]),
    .q_o       (cnt)
  );

  ra_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (ld_page_i),
    .ld_data_i (ld_data_i[PAGE_W-1:0]),
    .q_o       (page)
  );

  ra_addr_drv #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_drv (
    .win_i       (win_i),
    .cnt_i       (cnt),
    .page_i      (page),
    .addr_o      (ref_addr_o),
    .ref_strb_no (ref_strb_no),
    .mem_strb_no (mem_strb_no)
  );

  assign cnt_o  = cnt;
  assign page_o = page;
endmodule

// File: rtl/ra_refresh_gen_chk.sv
`timescale 1ns/1ps
module ra_refresh_gen_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned DAT_W  = 8,
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_done_i,
  input logic              win_i,
  input logic              ld_cnt_i,
  input logic              ld_page_i,
  input logic [DAT_W-1:0]  ld_data_i,
  input logic [ADDR_W-1:0] ref_addr_o,
  input logic              ref_strb_no,
  input logic              mem_strb_no,
  input logic [CNT_W-1:0]  cnt_o,
  input logic [PAGE_W-1:0] page_o
);
  localparam int unsigned CYC_W = CNT_W - 1;

  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_done_i && !ld_cnt_i) |=>
      cnt_o[CYC_W-1:0] == CYC_W'($past(cnt_o[CYC_W-1:0]) + 1'b1));

  a_r2_top_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_cnt_i |=> cnt_o[CNT_W-1] == $past(cnt_o[CNT_W-1]));

  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_cnt_i |=> cnt_o == $past(ld_data_i[CNT_W-1:0]));

  a_r5_page_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_page_i |=> $stable(page_o));

  a_r5_page_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_page_i |=> page_o == $past(ld_data_i[PAGE_W-1:0]));

  a_r6_strb_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_strb_no == mem_strb_no);

  a_r6_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_strb_no |-> ref_addr_o == {page_o, cnt_o});

  a_r7_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_i |-> (ref_strb_no && ref_addr_o == '0));
endmodule

bind ra_refresh_gen ra_refresh_gen_chk #(
  .CNT_W(CNT_W), .PAGE_W(PAGE_W), .DAT_W(DAT_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/ra_refresh_gen_tb.sv
`timescale 1ns/1ps
module ra_refresh_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch = 1'b0, win = 1'b0, ld_cnt = 1'b0, ld_page = 1'b0;
  logic [7:0]  ld_data = '0;
  logic [15:0] addr;
  logic        ref_n, mem_n;
  logic [7:0]  cnt, page;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  ra_refresh_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_done_i(fetch), .win_i(win),
    .ld_cnt_i(ld_cnt), .ld_page_i(ld_page), .ld_data_i(ld_data),
    .ref_addr_o(addr), .ref_strb_no(ref_n), .mem_strb_no(mem_n),
    .cnt_o(cnt), .page_o(page)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // inputs are set at a negedge; this applies them at one rising edge
  task automatic tick();
    @(posedge clk); @(negedge clk);
    fetch = 0; ld_cnt = 0; ld_page = 0;
  endtask

  task automatic load_cnt(input logic [7:0] v);
    ld_cnt = 1; ld_data = v; tick();
  endtask

  task automatic load_page(input logic [7:0] v);
    ld_page = 1; ld_data = v; tick();
  endtask

  task automatic t_reset();
    chk("R8 cnt", cnt, 8'h00);
    chk("R8 page", page, 8'h00);
    chk("R7 ref strobe idle", ref_n, 1'b1);
    chk("R7 mem strobe idle", mem_n, 1'b1);
    chk("R7 addr idle", addr, 16'h0000);
  endtask

  task automatic t_increment();
    for (int i = 1; i <= 5; i++) begin
      fetch = 1; tick();
      chk("R1 increment", cnt, 8'(i));
    end
    tick();
    chk("R1 no fetch holds", cnt, 8'h05);
  endtask

  task automatic t_wrap();
    load_cnt(8'h7F);
    chk("R4 load", cnt, 8'h7F);
    fetch = 1; tick();
    chk("R3 wrap 7F", cnt, 8'h00);
    load_cnt(8'hFF);
    fetch = 1; tick();
    chk("R3 wrap FF keeps bit7", cnt, 8'h80);
    fetch = 1; tick();
    chk("R2 bit7 kept on inc", cnt, 8'h81);
    load_cnt(8'h12);
    chk("R2 load clears bit7", cnt, 8'h12);
  endtask

  task automatic t_load_wins();
    fetch = 1; ld_cnt = 1; ld_data = 8'hB5; tick();
    chk("R4 load beats fetch", cnt, 8'hB5);
  endtask

  task automatic t_page();
    load_page(8'hA5);
    chk("R5 page load", page, 8'hA5);
    chk("R9 cnt readback untouched", cnt, 8'hB5);
    fetch = 1; tick();
    fetch = 1; tick();
    chk("R5 page holds across fetch", page, 8'hA5);
    chk("R9 cnt readback", cnt, 8'hB7);
  endtask

  task automatic t_window();
    win = 1; #0.5;
    chk("R6 addr in window", addr, 16'hA5B7);
    chk("R6 ref strobe", ref_n, 1'b0);
    chk("R6 mem strobe", mem_n, 1'b0);
    @(negedge clk);
    win = 0; #0.5;
    chk("R7 addr after window", addr, 16'h0000);
    chk("R7 ref strobe after window", ref_n, 1'b1);
    chk("R7 mem strobe after window", mem_n, 1'b1);
    // fetch then window: window shows advanced count
    fetch = 1; tick();
    win = 1; #0.5;
    chk("R6 addr after fetch", addr, 16'hA5B8);
    @(negedge clk);
    win = 0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_increment();
    t_wrap();
    t_load_wins();
    t_page();
    t_window();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule